// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

This block moves data between byte-addressed locations on a simple request/ready bus in place of the processor. It has four independent channels. Each channel holds a source address, a destination address, a 24-bit item count and a control word, all loaded through a write-only register port. A channel asks for service when it is enabled and either its own peripheral request line is high or its auto-request bit is set. One bus master port is shared between the channels under a fixed priority. Each item is read from the source and then written to the destination.

Two channels carry extra address handling. Channel 2 can snap its source address back to the last value written to it after every fourth item, which suits circular tables. Channel 3 can fetch each item indirectly. It first reads a 32-bit pointer, in two halfword reads, from its source address, and then reads the item from that pointer. A channel that finishes clears its enable, raises a done flag, and, if enabled, drives its interrupt line.

Top module: `dma4_engine`

## Requirements
- R1: A register write (`reg_we` high at a clock edge) selects the channel with `reg_addr[3:2]` and the field with `reg_addr[1:0]`: 0 source address, 1 destination address, 2 item count (low 24 bits), 3 control. The control bits are: bit0 enable, bits2:1 size, bit3 source increment, bit4 destination increment, bit5 auto-request, bit6 burst, bit7 interrupt enable, bit8 channel special mode.
- R2: In direct mode each item is two bus transactions. First comes a read at the source address, then a write of the read data to the destination address. The size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. The code appears on `bus_size`, and the data is right-justified on `bus_rdata`/`bus_wdata`.
- R3: After each item an address whose increment bit is set advances by 1, 2 or 4 bytes according to the size code. An address whose increment bit is clear stays fixed.
- R4: A transaction completes at a clock edge where `bus_req` and `bus_ready` are both high. While `bus_ready` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_size` hold their values.
- R5: Each completed item decrements the 24-bit count. A count written as 0 stands for 16,777,216 items, so the channel does not finish after a few items.
- R6: A channel is pending only when it is enabled and either its auto-request bit or its `dreq` line is high. A channel enabled with auto-request clear and `dreq` low starts no bus transaction.
- R7: When several channels are pending at an item boundary, channel 0 is served first and channel 3 last.
- R8: In cycle-steal mode `bus_req` drops for one cycle after every item. In burst mode `bus_req` stays high from the first item to the last.
- R9: When the last item's write completes, the channel clears its enable and sets `done`. `irq` equals `done` AND the interrupt enable. A write to the channel's control field clears `done`.
- R10: On channel 2 with special mode set, the source address returns to the last value written to the source field after every fourth completed item.
- R11: On channel 3 with special mode set, each item is four transactions. Two 16-bit reads at source and source+2 form a pointer, low half first. A read at the pointer follows, then the write to the destination. The source advances by 4 when its increment bit is set. On channels 0 and 1 the special bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel (bits 3:2) and field (bits 1:0) |
| reg_wdata | input | 32 | Register write data |
| dreq | input | 4 | Peripheral request, one per channel |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_size | output | 2 | Transaction size code |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ready | input | 1 | Transaction completes this cycle |
| done | output | 4 | Per-channel completion flags |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The hardest case to reach is the count-of-zero meaning, because 16,777,216 items cannot be run out. The bench instead writes a zero count, lets ten items pass, and confirms that `done` is still low. It then stops the channel with a control write. Arbitration order is also hard to see from outside. To expose it, two channels are held back by their request lines, both lines are raised in the same cycle, and the bench reads the order of source addresses from its bus trace. Random stalls on `bus_ready` run under every test, so the reload and indirect sequences are checked with gaps between transactions.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;

  // Control field layout; packed so field order matches register bits 8..0.
  typedef struct packed {
    logic       special;
    logic       irq_en;
    logic       burst;
    logic       auto_rq;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] size;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    F_SRC  = 2'd0,
    F_DST  = 2'd1,
    F_CNT  = 2'd2,
    F_CTRL = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PLO  = 3'd1,
    ST_PHI  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } mv_state_e;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(logic [1:0] s);
    case (s)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma4_pick.sv
module dma4_pick #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int CH           = 0,
  parameter int AW           = ADDR_W,
  parameter int CW           = CNT_W,
  parameter int RELOAD_CH    = 2,
  parameter int INDIRECT_CH  = 3,
  parameter int RELOAD_EVERY = 4,
  localparam int RCW         = (RELOAD_EVERY > 1) ? $clog2(RELOAD_EVERY) : 1,
  localparam bit HAS_RELOAD  = (CH == RELOAD_CH),
  localparam bit HAS_IND     = (CH == INDIRECT_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          dreq,
  input  logic          adv,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o,
  output logic          burst_o,
  output logic          last_o,
  output logic          pend_o,
  output logic          indir_o,
  output logic          done_o,
  output logic          irq_o
);
  logic [AW-1:0] src_q, src_n, dst_q, dst_n, init_q, init_n;
  logic [CW-1:0] cnt_q, cnt_n;
  ctrl_t         ctrl_q, ctrl_n;
  logic          done_q, done_n;
  logic          reload_hit;
  logic [AW-1:0] sstep, dstep;

  assign indir_o = HAS_IND && ctrl_q.special;
  assign last_o  = (cnt_q == CW'(1));
  assign sstep   = indir_o ? AW'(4) : AW'(size_bytes(ctrl_q.size));
  assign dstep   = AW'(size_bytes(ctrl_q.size));

  generate
    if (HAS_RELOAD) begin : g_reload
      logic [RCW-1:0] rc_q, rc_n;
      always_comb begin
        rc_n = rc_q;
        if (wr_en && (wr_field == F_SRC || wr_field == F_CTRL)) rc_n = '0;
        else if (adv && ctrl_q.special)
          rc_n = (rc_q == RCW'(RELOAD_EVERY - 1)) ? '0 : rc_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_n;
      end
      assign reload_hit = adv && ctrl_q.special && (rc_q == RCW'(RELOAD_EVERY - 1));
    end else begin : g_noreload
      assign reload_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    src_n  = src_q;
    dst_n  = dst_q;
    init_n = init_q;
    cnt_n  = cnt_q;
    ctrl_n = ctrl_q;
    done_n = done_q;
    if (adv) begin
      cnt_n = cnt_q - 1'b1;
      if (ctrl_q.src_inc) src_n = src_q + sstep;
      if (ctrl_q.dst_inc) dst_n = dst_q + dstep;
      if (reload_hit)     src_n = init_q;
      if (last_o) begin
        ctrl_n.en = 1'b0;
        done_n    = 1'b1;
      end
    end
    if (wr_en) begin
      case (wr_field)
        F_SRC:   begin src_n = wr_data; init_n = wr_data; end
        F_DST:   dst_n = wr_data;
        F_CNT:   cnt_n = wr_data[CW-1:0];
        default: begin ctrl_n = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]); done_n = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      init_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      src_q  <= src_n;
      dst_q  <= dst_n;
      init_q <= init_n;
      cnt_q  <= cnt_n;
      ctrl_q <= ctrl_n;
      done_q <= done_n;
    end
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign size_o  = ctrl_q.size;
  assign burst_o = ctrl_q.burst;
  assign pend_o  = ctrl_q.en && (ctrl_q.auto_rq || dreq);
  assign done_o  = done_q;
  assign irq_o   = done_q && ctrl_q.irq_en;

  // R5: one completed item lowers the count by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R9: the done flag rises only after the final item completes
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(adv && last_o));
  // R9: a finished channel no longer requests service
  a_r9_stop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_o && !wr_en) |=> !pend_o);
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int AW     = ADDR_W,
  parameter int IND_CH = 3,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HW    = AW / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         pend,
  input  logic [NCH-1:0][AW-1:0] src,
  input  logic [NCH-1:0][AW-1:0] dst,
  input  logic [NCH-1:0][1:0]    sz,
  input  logic [NCH-1:0]         burst,
  input  logic [NCH-1:0]         last,
  input  logic [NCH-1:0]         indir,
  output logic [NCH-1:0]         adv,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [1:0]             bus_size,
  output logic [AW-1:0]          bus_addr,
  output logic [AW-1:0]          bus_wdata,
  input  logic [AW-1:0]          bus_rdata,
  input  logic                   bus_ready
);
  mv_state_e      st_q, st_n;
  logic [CHW-1:0] ch_q, ch_n, pick;
  logic [AW-1:0]  ptr_q, ptr_n, data_q, data_n;
  logic           any;

  dma4_pick #(.N(NCH)) u_pick (.req(pend), .any(any), .idx(pick));

  always_comb begin
    st_n   = st_q;
    ch_n   = ch_q;
    ptr_n  = ptr_q;
    data_n = data_q;
    adv    = '0;
    case (st_q)
      ST_IDLE: if (any) begin
        ch_n = pick;
        st_n = indir[pick] ? ST_PLO : ST_RD;
      end
      ST_PLO: if (bus_ready) begin
        ptr_n[HW-1:0] = bus_rdata[HW-1:0];
        st_n = ST_PHI;
      end
      ST_PHI: if (bus_ready) begin
        ptr_n[AW-1:HW] = bus_rdata[HW-1:0];
        st_n = ST_RD;
      end
      ST_RD: if (bus_ready) begin
        data_n = bus_rdata & size_mask(sz[ch_q]);
        st_n = ST_WR;
      end
      ST_WR: if (bus_ready) begin
        adv[ch_q] = 1'b1;
        if (burst[ch_q] && !last[ch_q]) st_n = indir[ch_q] ? ST_PLO : ST_RD;
        else                            st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_n;
      ch_q   <= ch_n;
      ptr_q  <= ptr_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    bus_req   = (st_q != ST_IDLE);
    bus_we    = (st_q == ST_WR);
    bus_wdata = data_q;
    bus_size  = sz[ch_q];
    bus_addr  = src[ch_q];
    case (st_q)
      ST_PLO: bus_size = 2'd1;
      ST_PHI: begin bus_size = 2'd1; bus_addr = src[ch_q] + AW'(2); end
      ST_RD:  bus_addr = indir[ch_q] ? ptr_q : src[ch_q];
      ST_WR:  bus_addr = dst[ch_q];
      default: ;
    endcase
  end

  // R4: a stalled transaction keeps its attributes
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));
  // R8: cycle-steal gives the bus back after every item
  a_r8_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && bus_ready && !burst[ch_q]) |=> !bus_req);
  // R7: channel 0 pending at a boundary is always the one served
  a_r7_top_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pend[0]) |=> (ch_q == '0) && bus_req);
  // R11: pointer fetches happen only for the indirect-capable channel
  a_r11_ptr_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLO || st_q == ST_PHI) |-> ch_q == CHW'(IND_CH));
  // R8: at most one item completes per cycle
  a_r8_one_adv: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(adv));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int AW           = ADDR_W,
  parameter int CW           = CNT_W,
  parameter int RELOAD_CH    = 2,
  parameter int INDIRECT_CH  = 3,
  parameter int RELOAD_EVERY = 4,
  localparam int CHW         = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW         = CHW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  input  logic [NCH-1:0] dreq,
  output logic           bus_req,
  output logic           bus_we,
  output logic [1:0]     bus_size,
  output logic [AW-1:0]  bus_addr,
  output logic [AW-1:0]  bus_wdata,
  input  logic [AW-1:0]  bus_rdata,
  input  logic           bus_ready,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] irq
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [NCH-1:0][AW-1:0] src_v, dst_v;
  logic [NCH-1:0][1:0]    sz_v;
  logic [NCH-1:0]         burst_v, last_v, pend_v, indir_v, adv_v;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma4_chan #(
        .CH(i), .AW(AW), .CW(CW), .RELOAD_CH(RELOAD_CH),
        .INDIRECT_CH(INDIRECT_CH), .RELOAD_EVERY(RELOAD_EVERY)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .wr_en    (reg_we && (reg_addr[RAW-1:2] == CHW'(i))),
        .wr_field (reg_addr[1:0]),
        .wr_data  (reg_wdata),
        .dreq     (dreq[i]),
        .adv      (adv_v[i]),
        .src_o    (src_v[i]),
        .dst_o    (dst_v[i]),
        .size_o   (sz_v[i]),
        .burst_o  (burst_v[i]),
        .last_o   (last_v[i]),
        .pend_o   (pend_v[i]),
        .indir_o  (indir_v[i]),
        .done_o   (done[i]),
        .irq_o    (irq[i])
      );
    end
  endgenerate

  dma4_mover #(.NCH(NCH), .AW(AW), .IND_CH(INDIRECT_CH)) u_mover (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pend      (pend_v),
    .src       (src_v),
    .dst       (dst_v),
    .sz        (sz_v),
    .burst     (burst_v),
    .last      (last_v),
    .indir     (indir_v),
    .adv       (adv_v),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );
endmodule

// File: tb/dma4_engine_bench.sv
module dma4_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  dreq = '0;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic [3:0]  done, irq;

  dma4_engine u_dma4_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dreq(dreq), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  mem  [0:1023];
  logic [7:0]  emem [0:1023];
  logic        tr_we   [0:1023];
  logic [31:0] tr_addr [0:1023];
  logic [1:0]  tr_sz   [0:1023];
  int tr_n = 0;
  int checks = 0, errors = 0;
  bit stall = 1'b0;
  bit mon_en = 1'b0;
  int mon_ch = 0;
  int gaps = 0;
  bit finished = 1'b0;

  // Bus responder: decides ready at the falling edge; the transaction lands at the next rising edge.
  always @(negedge clk) begin
    int a, nb;
    bit r;
    if (rst_n) begin
      r = !stall && (($urandom % 4) != 0);
      a = int'(bus_addr[9:0]);
      bus_rdata = {mem[(a+3)&1023], mem[(a+2)&1023], mem[(a+1)&1023], mem[a]};
      bus_ready = r;
      if (r && bus_req) begin
        if (tr_n < 1024) begin
          tr_we[tr_n] = bus_we; tr_addr[tr_n] = bus_addr; tr_sz[tr_n] = bus_size;
        end
        tr_n++;
        if (bus_we) begin
          nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
          for (int k = 0; k < nb; k++) mem[(a+k)&1023] = bus_wdata[8*k +: 8];
        end
      end
      if (mon_en && !bus_req && !done[mon_ch]) gaps++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int field, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'((ch << 2) | field); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit en, int sz, bit si, bit di, bit au, bit bu, bit ie, bit sp);
    return 32'({sp, ie, bu, au, di, si, 2'(sz), en});
  endfunction

  task automatic cfg(input int ch, input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] n, input logic [31:0] c);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n); wr(ch, 3, c);
  endtask

  task automatic wait_done(input int ch, input string req);
    int n = 0;
    while (!done[ch] && n < 5000) begin @(negedge clk); n++; end
    if (!done[ch]) chk(1'b0, req, "channel never finished", 0, 1);
  endtask

  function automatic logic [31:0] rd_mem(int a);
    return {mem[(a+3)&1023], mem[(a+2)&1023], mem[(a+1)&1023], mem[a&1023]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WDOG", "run timed out", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int base, s, d, n, szc, nb, si, di, bad, ba, bv, be;
    logic [31:0] exp_a [0:7];
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(bus_req == 1'b0, "R4", "bus_req after reset", 32'(bus_req), 0);
    chk(done == 4'h0 && irq == 4'h0, "R9", "done/irq after reset", 32'({done, irq}), 0);

    // R1/R2/R4/R9: ch0 word copy with a forced stall on the first read
    stall = 1'b1;
    base = tr_n;
    cfg(0, 32'h100, 32'h200, 32'd4, ctl(1, 2, 1, 1, 1, 0, 1, 0));
    repeat (8) @(negedge clk);
    chk(bus_req && bus_addr == 32'h100 && !bus_we && tr_n == base, "R4",
        "stalled read holds", bus_addr, 32'h100);
    stall = 1'b0;
    wait_done(0, "R2");
    chk(tr_n - base == 8, "R2", "two transactions per item", tr_n - base, 8);
    chk(!tr_we[base] && tr_addr[base] == 32'h100 && tr_we[base+1] && tr_addr[base+1] == 32'h200
        && tr_sz[base] == 2'd2, "R1", "first read/write addresses", tr_addr[base+1], 32'h200);
    bad = 0;
    for (int k = 0; k < 16; k++) if (mem[32'h200 + k] != mem[32'h100 + k]) bad++;
    chk(bad == 0, "R3", "incrementing word copy mismatches", bad, 0);
    chk(done[0] && irq[0], "R9", "done and irq on ch0", 32'({done[0], irq[0]}), 3);
    wr(0, 3, 32'h0);
    @(negedge clk);
    chk(!done[0] && !irq[0], "R9", "control write clears done", 32'({done[0], irq[0]}), 0);

    // R2/R3: random direct copies compared with a shadow memory model
    for (int it = 0; it < 8; it++) begin
      szc = $urandom % 3; n = 1 + ($urandom % 6);
      si = $urandom % 2; di = $urandom % 2;
      s = $urandom % 64; d = 32'h300 + ($urandom % 64);
      nb = (szc == 0) ? 1 : (szc == 1) ? 2 : 4;
      for (int i = 0; i < 1024; i++) emem[i] = mem[i];
      ba = s; be = d;
      for (int k = 0; k < n; k++) begin
        for (int b = 0; b < nb; b++) emem[(be+b)&1023] = emem[(ba+b)&1023];
        if (si != 0) ba += nb;
        if (di != 0) be += nb;
      end
      cfg(1, s, d, n, ctl(1, szc, si[0], di[0], 1, it[0], 1'b0, 0));
      wait_done(1, "R3");
      bad = 0; bv = 0;
      for (int i = 32'h300; i < 32'h360; i++) if (mem[i] != emem[i]) begin bad++; bv = i; end
      chk(bad == 0, "R3", $sformatf("random copy %0d byte mismatches (last at %0h)", it, bv), bad, 0);
      chk(!irq[1], "R9", "irq stays low with irq enable clear", 32'(irq[1]), 0);
    end

    // R6: peripheral-request channel waits for its line
    base = tr_n;
    cfg(1, 32'h10, 32'h380, 32'd2, ctl(1, 0, 1, 1, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk(tr_n == base && !bus_req, "R6", "no transfer without dreq", tr_n - base, 0);
    dreq[1] = 1'b1;
    wait_done(1, "R6");
    dreq[1] = 1'b0;
    chk(tr_n - base == 4, "R6", "transfers once dreq raised", tr_n - base, 4);

    // R7: both lines raised together, ch0 served before ch1
    cfg(0, 32'h20, 32'h390, 32'd2, ctl(1, 2, 1, 1, 0, 0, 0, 0));
    cfg(1, 32'h40, 32'h3A0, 32'd2, ctl(1, 2, 1, 1, 0, 0, 0, 0));
    base = tr_n;
    @(negedge clk); dreq[1:0] = 2'b11;
    wait_done(0, "R7"); wait_done(1, "R7");
    dreq[1:0] = 2'b00;
    chk(tr_addr[base] == 32'h20 && tr_addr[base+2] == 32'h24 && tr_addr[base+4] == 32'h40,
        "R7", "service order by source address", tr_addr[base+4], 32'h40);

    // R8: bus release counted during burst and cycle-steal runs
    for (int mode = 0; mode < 2; mode++) begin
      base = tr_n; gaps = 0; mon_ch = 0;
      cfg(0, 32'h60, 32'h3B0, 32'd3, ctl(1, 1, 1, 1, 1, mode[0], 0, 0));
      while (tr_n == base) @(negedge clk);
      mon_en = 1'b1;
      wait_done(0, "R8");
      mon_en = 1'b0;
      chk(gaps == ((mode == 1) ? 0 : 2), "R8", mode ? "burst idle cycles" : "cycle-steal idle cycles",
          gaps, (mode == 1) ? 0 : 2);
    end

    // R10: ch2 source reload after every fourth item
    base = tr_n;
    cfg(2, 32'h100, 32'h3C0, 32'd6, ctl(1, 2, 1, 0, 1, 0, 0, 1));
    wait_done(2, "R10");
    exp_a[0] = 32'h100; exp_a[1] = 32'h104; exp_a[2] = 32'h108;
    exp_a[3] = 32'h10C; exp_a[4] = 32'h100; exp_a[5] = 32'h104;
    bad = 0;
    for (int k = 0; k < 6; k++) if (tr_addr[base + 2*k] != exp_a[k]) bad++;
    chk(bad == 0, "R10", "source read sequence with reload", tr_addr[base + 8], 32'h100);

    // R11: ch3 indirect fetch through a pointer table
    {mem[32'h143], mem[32'h142], mem[32'h141], mem[32'h140]} = 32'h0000_0180;
    {mem[32'h147], mem[32'h146], mem[32'h145], mem[32'h144]} = 32'h0000_0190;
    {mem[32'h183], mem[32'h182], mem[32'h181], mem[32'h180]} = 32'hDDCC_BBAA;
    {mem[32'h193], mem[32'h192], mem[32'h191], mem[32'h190]} = 32'h4433_2211;
    base = tr_n;
    cfg(3, 32'h140, 32'h3E0, 32'd2, ctl(1, 2, 1, 1, 1, 0, 0, 1));
    wait_done(3, "R11");
    chk(tr_n - base == 8, "R11", "four transactions per item", tr_n - base, 8);
    chk(tr_addr[base] == 32'h140 && tr_sz[base] == 2'd1 && tr_addr[base+1] == 32'h142
        && tr_addr[base+2] == 32'h180 && tr_we[base+3] && tr_addr[base+4] == 32'h144
        && tr_addr[base+6] == 32'h190, "R11", "indirect address sequence", tr_addr[base+6], 32'h190);
    chk(rd_mem(32'h3E0) == 32'hDDCC_BBAA && rd_mem(32'h3E4) == 32'h4433_2211, "R11",
        "indirect data copied", rd_mem(32'h3E4), 32'h4433_2211);
    base = tr_n;
    cfg(0, 32'h140, 32'h3F0, 32'd1, ctl(1, 2, 1, 1, 1, 0, 0, 1));
    wait_done(0, "R11");
    chk(tr_n - base == 2 && tr_addr[base] == 32'h140, "R11", "special bit ignored on ch0",
        tr_n - base, 2);

    // R5: count of zero runs far past a handful of items
    base = tr_n;
    cfg(1, 32'h8, 32'h3F8, 32'd0, ctl(1, 0, 0, 0, 1, 0, 0, 0));
    while (tr_n < base + 20) @(negedge clk);
    chk(!done[1], "R5", "zero count not finished after ten items", 32'(done[1]), 0);
    wr(1, 3, 32'h0);
    repeat (20) @(negedge clk);
    chk(!bus_req, "R5", "bus idle after channel stopped", 32'(bus_req), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule